// File: doc/BRIEF.md
# Stereo Attenuation and Output Mixer

This block sits in an audio playback path between the serial input stage and the oversampling filters. Each cycle it can accept a pair of signed left and right samples together with a valid strobe. Each channel is scaled by its own 8-bit gain step. Step 255 passes the sample through unchanged, step 0 silences it, and every other step x scales the sample by x/256.

The two scaled channels then pass through a routing matrix. A 4-bit mode word picks a source for each output independently: silence, the right channel, the left channel, or the mean of the two. This covers normal stereo, swapped channels and mono downmix.

Three overrides can drive both outputs to the two's-complement zero code: a soft mute, an output disable, and a zero-input flag that takes effect only when zero detection is enabled. The result is registered once, and the output valid strobe travels alongside it.

Top module: `stereo_gain_mixer`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and both output samples are 0.
- R2: For a gain step x between 1 and 254, the scaled channel is floor(sample * x / 256), so the rounding is toward minus infinity.
- R3: Gain step 255 applies a gain of exactly 256/256, and the scaled channel equals the input sample.
- R4: Gain step 0 makes the scaled channel 0 whatever the sample is.
- R5: When `gain_shared` is 1, `gain_left` scales both channels and `gain_right` has no effect on either output.
- R6: `route_mode[3:2]` picks the source of `out_left` and `route_mode[1:0]` picks the source of `out_right`. The encoding is 00 = silence, 01 = scaled right, 10 = scaled left, 11 = mean. So 4'b1001 gives stereo and 4'b0110 swaps the channels.
- R7: The mean output is floor((L + R) / 2) of the scaled channels. It is computed one bit wider than the samples, so full-scale inputs of the same sign do not wrap.
- R8: When `soft_mute` is 1, both outputs carry 0 for that sample.
- R9: When `out_disable` is 1, both outputs carry 0 for that sample regardless of the data.
- R10: When `zero_detect_en` and `zero_flag` are both 1, both outputs carry 0. When `zero_detect_en` is 0, `zero_flag` has no effect on the outputs.
- R11: Outputs for a sample accepted at a clock edge appear after that edge with `out_valid` set to 1. A cycle with `in_valid` low gives `out_valid` = 0 and leaves both output samples unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample pair is present |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| gain_left | input | STEP_W | Left gain step |
| gain_right | input | STEP_W | Right gain step |
| gain_shared | input | 1 | Apply the left gain step to both channels |
| route_mode | input | 4 | Output source selection, two bits per output |
| soft_mute | input | 1 | Silence both outputs |
| out_disable | input | 1 | Force both outputs to midscale zero |
| zero_detect_en | input | 1 | Allow the zero flag to act |
| zero_flag | input | 1 | Input has been continuously zero |
| out_valid | output | 1 | Output sample pair is present |
| out_left | output | SAMPLE_W | Left output sample |
| out_right | output | SAMPLE_W | Right output sample |

## Verification
The only register between any input and any output is the output stage. Every result is therefore due at the first rising edge after the inputs are applied, and that includes the override effects and the valid strobe.

The bench changes inputs on the falling edge and samples the outputs on the next falling edge, which is half a cycle after the edge that loads the register. An idle cycle follows each sample, and the hold checks read the outputs across several idle cycles to confirm that nothing moves. The expected values come from integer arithmetic in the bench, using the floor rule for the gain and for the mean.

// File: rtl/sgm_pkg.sv
package sgm_pkg;

   // Source choice for one output, two bits per output in route_mode
   typedef enum logic [1:0] {
      SRC_SILENT = 2'b00,
      SRC_RIGHT  = 2'b01,
      SRC_LEFT   = 2'b10,
      SRC_MEAN   = 2'b11
   } src_sel_e;

   localparam int NUM_CH   = 2;
   localparam int MODE_W   = 4;
   localparam int SEL_W    = MODE_W / NUM_CH;

endpackage

// File: rtl/sgm_gain.sv
module sgm_gain #(
   parameter int SAMPLE_W = 18,
   parameter int STEP_W   = 8
) (
   input  logic signed [SAMPLE_W-1:0] sample_i,
   input  logic        [STEP_W-1:0]   step_i,
   output logic signed [SAMPLE_W-1:0] scaled_o
);

   localparam int Y_W    = STEP_W + 1;
   localparam int PROD_W = SAMPLE_W + Y_W;
   localparam logic [Y_W-1:0] Y_UNITY = Y_W'(1) << STEP_W;

   logic [Y_W-1:0]           y_mult;
   logic signed [PROD_W-1:0] a_ext;
   logic signed [PROD_W-1:0] b_ext;
   logic signed [PROD_W-1:0] product;

   // Top step maps to an exact power of two so the gain is exactly one
   always_comb begin
      if (step_i == {STEP_W{1'b1}}) y_mult = Y_UNITY;
      else                          y_mult = {1'b0, step_i};
   end

   always_comb begin
      a_ext    = {{(PROD_W-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
      b_ext    = {{(PROD_W-Y_W){1'b0}}, y_mult};
      product  = a_ext * b_ext;
      // Dropping the low bits is an arithmetic shift right: floor division
      scaled_o = product[STEP_W +: SAMPLE_W];
   end

endmodule

// File: rtl/sgm_route.sv
module sgm_route
   import sgm_pkg::*;
#(
   parameter int SAMPLE_W = 18
) (
   input  logic signed [SAMPLE_W-1:0] left_i,
   input  logic signed [SAMPLE_W-1:0] right_i,
   input  logic        [SEL_W-1:0]    sel_i,
   output logic signed [SAMPLE_W-1:0] mix_o
);

   logic signed [SAMPLE_W:0] sum_wide;

   // One guard bit keeps the sum exact, then drop bit 0 for floor(sum/2)
   always_comb begin
      sum_wide = {left_i[SAMPLE_W-1], left_i} + {right_i[SAMPLE_W-1], right_i};
   end

   always_comb begin
      unique case (src_sel_e'(sel_i))
         SRC_SILENT: mix_o = '0;
         SRC_RIGHT:  mix_o = right_i;
         SRC_LEFT:   mix_o = left_i;
         SRC_MEAN:   mix_o = sum_wide[SAMPLE_W:1];
         default:    mix_o = '0;
      endcase
   end

endmodule

// File: rtl/sgm_out_stage.sv
module sgm_out_stage
   import sgm_pkg::*;
#(
   parameter int SAMPLE_W = 18
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       valid_i,
   input  logic                       force_zero_i,
   input  logic signed [SAMPLE_W-1:0] mix_i [NUM_CH],
   output logic                       valid_o,
   output logic signed [SAMPLE_W-1:0] data_o [NUM_CH]
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_o <= 1'b0;
      else        valid_o <= valid_i;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       data_o[ch] <= '0;
         else if (valid_i) data_o[ch] <= force_zero_i ? '0 : mix_i[ch];
      end
   end

endmodule

// File: rtl/stereo_gain_mixer.sv
module stereo_gain_mixer
   import sgm_pkg::*;
#(
   parameter int SAMPLE_W = 18,
   parameter int STEP_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_left,
   input  logic signed [SAMPLE_W-1:0] in_right,
   input  logic        [STEP_W-1:0]   gain_left,
   input  logic        [STEP_W-1:0]   gain_right,
   input  logic                       gain_shared,
   input  logic        [3:0]          route_mode,
   input  logic                       soft_mute,
   input  logic                       out_disable,
   input  logic                       zero_detect_en,
   input  logic                       zero_flag,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_left,
   output logic signed [SAMPLE_W-1:0] out_right
);

   if (SAMPLE_W < 4) begin : g_bad_sample_w
      $error("stereo_gain_mixer: SAMPLE_W must be at least 4");
   end
   if (STEP_W < 2 || STEP_W > 16) begin : g_bad_step_w
      $error("stereo_gain_mixer: STEP_W must lie in 2..16");
   end

   localparam int CH_L = 0;
   localparam int CH_R = 1;

   logic signed [SAMPLE_W-1:0] raw    [NUM_CH];
   logic        [STEP_W-1:0]   step   [NUM_CH];
   logic signed [SAMPLE_W-1:0] scaled [NUM_CH];
   logic signed [SAMPLE_W-1:0] mixed  [NUM_CH];
   logic        [SEL_W-1:0]    sel    [NUM_CH];
   logic signed [SAMPLE_W-1:0] held   [NUM_CH];
   logic                       force_zero;

   always_comb begin
      raw[CH_L]  = in_left;
      raw[CH_R]  = in_right;
      step[CH_L] = gain_left;
      step[CH_R] = gain_shared ? gain_left : gain_right;
      sel[CH_L]  = route_mode[3:2];
      sel[CH_R]  = route_mode[1:0];
      force_zero = soft_mute | out_disable | (zero_detect_en & zero_flag);
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gain
      sgm_gain #(
         .SAMPLE_W (SAMPLE_W),
         .STEP_W   (STEP_W)
      ) u_gain (
         .sample_i (raw[ch]),
         .step_i   (step[ch]),
         .scaled_o (scaled[ch])
      );
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_route
      sgm_route #(
         .SAMPLE_W (SAMPLE_W)
      ) u_route (
         .left_i  (scaled[CH_L]),
         .right_i (scaled[CH_R]),
         .sel_i   (sel[ch]),
         .mix_o   (mixed[ch])
      );
   end

   sgm_out_stage #(
      .SAMPLE_W (SAMPLE_W)
   ) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .valid_i      (in_valid),
      .force_zero_i (force_zero),
      .mix_i        (mixed),
      .valid_o      (out_valid),
      .data_o       (held)
   );

   assign out_left  = held[CH_L];
   assign out_right = held[CH_R];

endmodule

// File: rtl/sgm_checker.sv
module sgm_checker #(
   parameter int SAMPLE_W = 18,
   parameter int STEP_W   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic signed [SAMPLE_W-1:0] in_left,
   input logic signed [SAMPLE_W-1:0] in_right,
   input logic        [STEP_W-1:0]   gain_left,
   input logic        [STEP_W-1:0]   gain_right,
   input logic                       gain_shared,
   input logic        [3:0]          route_mode,
   input logic                       soft_mute,
   input logic                       out_disable,
   input logic                       zero_detect_en,
   input logic                       zero_flag,
   input logic                       out_valid,
   input logic signed [SAMPLE_W-1:0] out_left,
   input logic signed [SAMPLE_W-1:0] out_right
);

   always_comb begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (out_valid == 1'b0);
      end
   end

   assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

   assert_soft_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && soft_mute) |=> (out_left == '0 && out_right == '0));

   assert_disable_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && out_disable) |=> (out_left == '0 && out_right == '0));

   assert_zero_detect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && zero_detect_en && zero_flag) |=> (out_left == '0 && out_right == '0));

   assert_unity_stereo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && route_mode == 4'b1001 && gain_left == '1 && gain_right == '1 &&
       !soft_mute && !out_disable && !(zero_detect_en && zero_flag))
      |=> (out_left == $past(in_left) && out_right == $past(in_right)));

   assert_silent_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && route_mode == 4'b0000) |=> (out_left == '0 && out_right == '0));

   assert_zero_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && gain_left == '0 && (gain_shared || gain_right == '0))
      |=> (out_left == '0 && out_right == '0));

endmodule

bind stereo_gain_mixer sgm_checker #(
   .SAMPLE_W (SAMPLE_W),
   .STEP_W   (STEP_W)
) u_sgm_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .in_left        (in_left),
   .in_right       (in_right),
   .gain_left      (gain_left),
   .gain_right     (gain_right),
   .gain_shared    (gain_shared),
   .route_mode     (route_mode),
   .soft_mute      (soft_mute),
   .out_disable    (out_disable),
   .zero_detect_en (zero_detect_en),
   .zero_flag      (zero_flag),
   .out_valid      (out_valid),
   .out_left       (out_left),
   .out_right      (out_right)
);

// File: tb/test_stereo_gain_mixer.sv
module test_stereo_gain_mixer;

   localparam int CLK_PERIOD = 10;
   localparam int SW = 18;
   localparam int GW = 8;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [SW-1:0] in_left = '0;
   logic signed [SW-1:0] in_right = '0;
   logic        [GW-1:0] gain_left = '0;
   logic        [GW-1:0] gain_right = '0;
   logic                 gain_shared = 1'b0;
   logic        [3:0]    route_mode = 4'b1001;
   logic                 soft_mute = 1'b0;
   logic                 out_disable = 1'b0;
   logic                 zero_detect_en = 1'b0;
   logic                 zero_flag = 1'b0;
   logic                 out_valid;
   logic signed [SW-1:0] out_left;
   logic signed [SW-1:0] out_right;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stereo_gain_mixer #(.SAMPLE_W(SW), .STEP_W(GW)) i_stereo_gain_mixer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_left(in_left), .in_right(in_right),
      .gain_left(gain_left), .gain_right(gain_right), .gain_shared(gain_shared),
      .route_mode(route_mode), .soft_mute(soft_mute), .out_disable(out_disable),
      .zero_detect_en(zero_detect_en), .zero_flag(zero_flag),
      .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
   );

   function automatic longint scale(longint s, int x);
      longint y = (x == 255) ? 256 : longint'(x);
      return (s * y) >>> 8;
   endfunction

   function automatic longint pick(int sel, longint l, longint r);
      case (sel)
         0: return 0;
         1: return r;
         2: return l;
         default: return (l + r) >>> 1;
      endcase
   endfunction

   task automatic check(string req, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Apply one sample pair, then read results half a cycle after the loading edge
   task automatic apply(input longint l, input longint r, input int gl, input int gr,
                        input bit sh, input int mode, input bit sm, input bit od,
                        input bit zde, input bit zf, input string req);
      longint sl, sr, el, er;
      @(negedge clk);
      in_left = SW'(l); in_right = SW'(r);
      gain_left = GW'(gl); gain_right = GW'(gr); gain_shared = sh;
      route_mode = 4'(mode); soft_mute = sm; out_disable = od;
      zero_detect_en = zde; zero_flag = zf; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      sl = scale(l, gl);
      sr = scale(r, sh ? gl : gr);
      el = pick((mode >> 2) & 3, sl, sr);
      er = pick(mode & 3, sl, sr);
      if (sm || od || (zde && zf)) begin el = 0; er = 0; end
      check({req, " left"},  longint'(out_left),  el);
      check({req, " right"}, longint'(out_right), er);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      longint smp [6] = '{-131072, 131071, 0, -1, 12345, -77777};
      longint hl, hr;
      string tag;

      repeat (3) @(negedge clk);
      check("R1 valid in reset", longint'(out_valid), 0);
      check("R1 left in reset",  longint'(out_left),  0);
      check("R1 right in reset", longint'(out_right), 0);
      rst_n = 1'b1;

      // R2 R3 R4: every gain step, stereo routing
      for (int x = 0; x < 256; x++) begin
         for (int k = 0; k < 6; k++) begin
            tag = (x == 255) ? "R3" : (x == 0) ? "R4" : "R2";
            apply(smp[k], smp[5-k], x, 255 - x, 1'b0, 4'b1001, 0, 0, 0, 0, tag);
         end
      end

      // R5 R6 R7: every routing code, separate and shared gain
      for (int m = 0; m < 16; m++) begin
         for (int sh = 0; sh < 2; sh++) begin
            for (int k = 0; k < 6; k++) begin
               tag = (sh == 1) ? "R5" : ((m & 3) == 3 || (m >> 2) == 3) ? "R7" : "R6";
               apply(smp[k], smp[(k+2)%6], 200, 77, sh[0], m, 0, 0, 0, 0, tag);
            end
         end
      end

      // R7: same-sign full scale must not wrap in the mean
      apply(131071, 131071, 255, 255, 0, 4'b1111, 0, 0, 0, 0, "R7 max mean");
      apply(-131072, -131072, 255, 255, 0, 4'b1111, 0, 0, 0, 0, "R7 min mean");
      apply(-131072, 131071, 255, 255, 0, 4'b1111, 0, 0, 0, 0, "R7 mixed mean");

      // R8 R9 R10: overrides
      for (int k = 0; k < 6; k++) begin
         apply(smp[k], smp[5-k], 255, 255, 0, 4'b1001, 1, 0, 0, 0, "R8");
         apply(smp[k], smp[5-k], 255, 255, 0, 4'b1001, 0, 1, 0, 0, "R9");
         apply(smp[k], smp[5-k], 255, 255, 0, 4'b1001, 0, 0, 1, 1, "R10 enabled");
         apply(smp[k], smp[5-k], 255, 255, 0, 4'b1001, 0, 0, 0, 1, "R10 disabled");
         apply(smp[k], smp[5-k], 255, 255, 0, 4'b1001, 0, 0, 1, 0, "R10 flag low");
      end

      // R11: valid aligned to data, idle cycles hold the outputs
      @(negedge clk);
      in_left = 18'sd5000; in_right = -18'sd6000;
      gain_left = 8'd255; gain_right = 8'd255; gain_shared = 0;
      route_mode = 4'b0110; soft_mute = 0; out_disable = 0;
      zero_detect_en = 0; zero_flag = 0; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 valid after accept", longint'(out_valid), 1);
      check("R11 swapped left",  longint'(out_left),  -6000);
      check("R11 swapped right", longint'(out_right), 5000);
      hl = longint'(out_left); hr = longint'(out_right);
      in_left = 18'sd77; in_right = 18'sd99; route_mode = 4'b1111; soft_mute = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R11 idle valid", longint'(out_valid), 0);
         check("R11 idle left",  longint'(out_left),  hl);
         check("R11 idle right", longint'(out_right), hr);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule